// File: doc/BRIEF.md
# Periodic Compare-Triggered Conversion Start Controller

This block runs a free-running timer and compares it every cycle with a programmed value. When the compare-mode field selects the trigger mode and the timer equals the compare value, the block reloads the timer to zero. If the converter is enabled and idle at that point, the same event also launches a conversion. Each conversion runs as a programmable acquisition window, then a one-cycle start strobe to the converter, then a wait for the converter's done pulse. Because the compare match also restarts the timebase, the block keeps sampling at a fixed period with no software action.

Software writes the compare value, the mode field and a control word through a simple write port. Software may also start a conversion directly. A software start runs the same acquisition and conversion sequence, but it leaves the timer alone.

Top module: `conv_trigger_ctrl`

## Requirements
- R1: A trigger event (`trig_evt` high) occurs in a cycle exactly when the mode field equals 4'b1011 and `timer_q` equals the compare value. With any other mode the timer counts up by one per cycle and wraps from 16'hFFFF to 0.
- R2: A trigger in a cycle where the enable bit is set and the sequencer is idle makes `busy` high from the next cycle on.
- R3: Every trigger makes `timer_q` equal to 0 in the next cycle, whether or not the converter is enabled. In the trigger mode, triggers therefore repeat every compare+1 cycles.
- R4: A trigger while the enable bit is clear leaves `busy` low.
- R5: After a start, `acq_active` stays high for the number of cycles the 3-bit acquisition field selects. Field values 0 to 7 select 0, 2, 4, 6, 8, 12, 16 and 20 cycles. `conv_start` is then high for exactly one cycle.
- R6: When `wr_en` is high, a write takes effect on the clock edge. Address 0 writes the 16-bit compare value. Address 1 writes the mode field from `wr_data[3:0]`. Address 2 writes the control word: bit 0 is enable, bit 1 is software start and bits 4:2 are the acquisition field. A start in that same cycle uses the acquisition field from that write.
- R7: A `conv_done` pulse that arrives after the start strobe, while `busy` is high, makes `busy` low and `done_flag` high for exactly one cycle, both from the next cycle. A `conv_done` pulse at any other time is ignored.
- R8: A trigger while `busy` is high, including in the cycle of the done pulse, still reloads the timer. It neither restarts nor lengthens the sequence in progress.
- R9: A control write with bits 1 and 0 both set starts the sequence when the sequencer is idle, and the timer is not reloaded. Such a write is ignored while `busy` is high.
- R10: While synchronous `rst` is high, the timer, compare value, mode field, control bits and sequencer all clear. After reset `timer_q` is 0 and `busy`, `acq_active`, `conv_start` and `done_flag` are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock; one period is one converter clock |
| rst | input | 1 | Synchronous active-high reset |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 2 | Register select: 0 compare, 1 mode, 2 control |
| wr_data | input | 16 | Write data |
| conv_done | input | 1 | Conversion-finished pulse from the converter |
| timer_q | output | 16 | Current timer value |
| trig_evt | output | 1 | Compare match in trigger mode this cycle |
| busy | output | 1 | Start/busy status |
| acq_active | output | 1 | Acquisition window in progress |
| conv_start | output | 1 | One-cycle conversion start strobe to the converter |
| done_flag | output | 1 | One-cycle conversion-complete flag |

## Verification
Two pairs of events can land in the same cycle. A trigger can meet the converter's done pulse, and a trigger can meet a software start write. The bench provokes the first by sweeping the converter response latency against a short compare period. It provokes the second by issuing software starts at a range of offsets from the expected match. A behavioural reference model judges each cycle. It expects a trigger that coincides with done to reload the timer and start nothing, and it expects a coinciding software start and trigger to produce one sequence, with the timer reloaded by the trigger.

// File: rtl/conv_trigger_pkg.sv
package conv_trigger_pkg;

  localparam int TMR_W   = 16;
  localparam int MODE_W  = 4;
  localparam int ACQ_W   = 3;
  localparam int CNT_W   = 5;
  localparam int ADDR_W  = 2;

  localparam logic [MODE_W-1:0] TRIG_MODE = 4'b1011;

  localparam logic [ADDR_W-1:0] A_CMP  = 2'd0;
  localparam logic [ADDR_W-1:0] A_MODE = 2'd1;
  localparam logic [ADDR_W-1:0] A_CTRL = 2'd2;

  localparam int B_EN  = 0;
  localparam int B_GO  = 1;
  localparam int B_ACQ = 2;

  typedef enum logic [1:0] {
    SQ_IDLE  = 2'd0,
    SQ_ACQ   = 2'd1,
    SQ_START = 2'd2,
    SQ_CONV  = 2'd3
  } seq_state_t;

  // acquisition length in converter clocks for each field value
  function automatic logic [CNT_W-1:0] acq_cycles(input logic [ACQ_W-1:0] sel);
    logic [CNT_W-1:0] r;
    case (sel)
      3'd0:    r = 5'd0;
      3'd1:    r = 5'd2;
      3'd2:    r = 5'd4;
      3'd3:    r = 5'd6;
      3'd4:    r = 5'd8;
      3'd5:    r = 5'd12;
      3'd6:    r = 5'd16;
      default: r = 5'd20;
    endcase
    return r;
  endfunction

endpackage

// File: rtl/conv_trigger_regs.sv
module conv_trigger_regs
  import conv_trigger_pkg::*;
#(
  parameter int DW = TMR_W
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              wr_en,
  input  logic [ADDR_W-1:0] wr_addr,
  input  logic [DW-1:0]     wr_data,
  output logic [DW-1:0]     cmp_val,
  output logic [MODE_W-1:0] mode_val,
  output logic              en_val,
  output logic [ACQ_W-1:0]  acq_val,
  output logic [ACQ_W-1:0]  acq_eff,
  output logic              sw_go
);

  logic ctrl_wr;
  assign ctrl_wr = wr_en && (wr_addr == A_CTRL);

  always_ff @(posedge clk) begin
    if (rst) begin
      cmp_val  <= '0;
      mode_val <= '0;
      en_val   <= 1'b0;
      acq_val  <= '0;
    end else if (wr_en) begin
      case (wr_addr)
        A_CMP:  cmp_val  <= wr_data;
        A_MODE: mode_val <= wr_data[MODE_W-1:0];
        A_CTRL: begin
          en_val  <= wr_data[B_EN];
          acq_val <= wr_data[B_ACQ +: ACQ_W];
        end
        default: ;
      endcase
    end
  end

  // a start written with the control word uses that word's fields
  assign sw_go   = ctrl_wr && wr_data[B_GO] && wr_data[B_EN];
  assign acq_eff = ctrl_wr ? wr_data[B_ACQ +: ACQ_W] : acq_val;

  AST_CMP_WRITE: assert property (@(posedge clk) disable iff (rst)
    (wr_en && wr_addr == A_CMP) |=> cmp_val == $past(wr_data)); // R6

endmodule

// File: rtl/conv_trigger_timebase.sv
module conv_trigger_timebase
  import conv_trigger_pkg::*;
#(
  parameter int W = TMR_W
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [W-1:0]      cmp_val,
  input  logic [MODE_W-1:0] mode_val,
  output logic [W-1:0]      timer_q,
  output logic              trig_evt
);

  localparam logic [W-1:0] ONE = W'(1);

  assign trig_evt = (mode_val == TRIG_MODE) && (timer_q == cmp_val);

  always_ff @(posedge clk) begin
    if (rst)           timer_q <= '0;
    else if (trig_evt) timer_q <= '0;
    else               timer_q <= timer_q + ONE;
  end

  AST_TRIG_RELOAD: assert property (@(posedge clk) disable iff (rst)
    trig_evt |=> timer_q == '0); // R3
  AST_TIMER_STEP: assert property (@(posedge clk) disable iff (rst)
    !trig_evt |=> timer_q == $past(timer_q) + ONE); // R1

endmodule

// File: rtl/conv_trigger_seq.sv
module conv_trigger_seq
  import conv_trigger_pkg::*;
(
  input  logic             clk,
  input  logic             rst,
  input  logic             start_req,
  input  logic [ACQ_W-1:0] acq_sel,
  input  logic             conv_done,
  output logic             busy,
  output logic             acq_active,
  output logic             conv_start,
  output logic             done_flag
);

  seq_state_t       st_q;
  logic [CNT_W-1:0] cnt_q;
  logic [CNT_W-1:0] load_len;
  logic             acq_last;

  assign load_len = acq_cycles(acq_sel);
  assign acq_last = (st_q == SQ_ACQ) && (cnt_q == CNT_W'(1));

  always_ff @(posedge clk) begin
    if (rst) begin
      st_q      <= SQ_IDLE;
      cnt_q     <= '0;
      done_flag <= 1'b0;
    end else begin
      done_flag <= 1'b0;
      case (st_q)
        SQ_IDLE: if (start_req) begin
          cnt_q <= load_len;
          st_q  <= (load_len == '0) ? SQ_START : SQ_ACQ;
        end
        SQ_ACQ: begin
          cnt_q <= cnt_q - CNT_W'(1);
          if (acq_last) st_q <= SQ_START;
        end
        SQ_START: st_q <= SQ_CONV;
        SQ_CONV: if (conv_done) begin
          st_q      <= SQ_IDLE;
          done_flag <= 1'b1;
        end
        default: st_q <= SQ_IDLE;
      endcase
    end
  end

  assign busy       = (st_q != SQ_IDLE);
  assign acq_active = (st_q == SQ_ACQ);
  assign conv_start = (st_q == SQ_START);

  AST_ACQ_TO_START: assert property (@(posedge clk) disable iff (rst)
    acq_last |=> conv_start); // R5
  AST_START_PULSE: assert property (@(posedge clk) disable iff (rst)
    conv_start |=> (!conv_start && busy && !acq_active)); // R5
  AST_FLAG_PULSE: assert property (@(posedge clk) disable iff (rst)
    done_flag |=> !done_flag); // R7

endmodule

// File: rtl/conv_trigger_ctrl.sv
module conv_trigger_ctrl
  import conv_trigger_pkg::*;
(
  input  logic              clk,
  input  logic              rst,
  input  logic              wr_en,
  input  logic [ADDR_W-1:0] wr_addr,
  input  logic [TMR_W-1:0]  wr_data,
  input  logic              conv_done,
  output logic [TMR_W-1:0]  timer_q,
  output logic              trig_evt,
  output logic              busy,
  output logic              acq_active,
  output logic              conv_start,
  output logic              done_flag
);

  logic [TMR_W-1:0]  cmp_val;
  logic [MODE_W-1:0] mode_val;
  logic              en_val;
  logic [ACQ_W-1:0]  acq_val;
  logic [ACQ_W-1:0]  acq_eff;
  logic              sw_go;
  logic              hw_go;
  logic              start_req;

  conv_trigger_regs #(.DW(TMR_W)) u_regs (
    .clk      (clk),
    .rst      (rst),
    .wr_en    (wr_en),
    .wr_addr  (wr_addr),
    .wr_data  (wr_data),
    .cmp_val  (cmp_val),
    .mode_val (mode_val),
    .en_val   (en_val),
    .acq_val  (acq_val),
    .acq_eff  (acq_eff),
    .sw_go    (sw_go)
  );

  conv_trigger_timebase #(.W(TMR_W)) u_tb (
    .clk      (clk),
    .rst      (rst),
    .cmp_val  (cmp_val),
    .mode_val (mode_val),
    .timer_q  (timer_q),
    .trig_evt (trig_evt)
  );

  // named start sources, the sequencer accepts them only when idle
  assign hw_go     = trig_evt && en_val;
  assign start_req = hw_go || sw_go;

  conv_trigger_seq u_seq (
    .clk        (clk),
    .rst        (rst),
    .start_req  (start_req),
    .acq_sel    (acq_eff),
    .conv_done  (conv_done),
    .busy       (busy),
    .acq_active (acq_active),
    .conv_start (conv_start),
    .done_flag  (done_flag)
  );

  AST_EN_START: assert property (@(posedge clk) disable iff (rst)
    (trig_evt && en_val && !busy) |=> busy); // R2
  AST_DIS_IGNORE: assert property (@(posedge clk) disable iff (rst)
    (trig_evt && !en_val && !sw_go && !busy) |=> !busy); // R4
  AST_DONE_CLEAR: assert property (@(posedge clk) disable iff (rst)
    (busy && !acq_active && !conv_start && conv_done) |=> (!busy && done_flag)); // R7
  AST_BUSY_HOLD: assert property (@(posedge clk) disable iff (rst)
    (busy && !conv_done) |=> busy); // R8
  AST_SW_START: assert property (@(posedge clk) disable iff (rst)
    (sw_go && !busy) |=> busy); // R9

endmodule

// File: tb/test_conv_trigger_ctrl.sv
module test_conv_trigger_ctrl;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        wr_en = 1'b0;
  logic [1:0]  wr_addr = '0;
  logic [15:0] wr_data = '0;
  logic        conv_done;
  logic [15:0] timer_q;
  logic        trig_evt, busy, acq_active, conv_start, done_flag;

  always #5 clk = ~clk;

  conv_trigger_ctrl i_conv_trigger_ctrl (
    .clk(clk), .rst(rst), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
    .conv_done(conv_done), .timer_q(timer_q), .trig_evt(trig_evt), .busy(busy),
    .acq_active(acq_active), .conv_start(conv_start), .done_flag(done_flag)
  );

  int total = 0;
  int bad = 0;
  bit finished = 0;
  bit cmp_on = 0;

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%0d expected=%0d at %0t", tag, act, exp, $time);
    end
  endtask

  // ---------------- behavioural reference model ----------------
  int m_timer, m_cmp, m_mode, m_en, m_acq, m_state, m_cnt, m_flag;

  function automatic int acq_len(input int v);
    if (v <= 4) return 2 * v;
    return 8 + 4 * (v - 4);
  endfunction

  function automatic bit m_trig();
    return (m_mode == 11) && (m_timer == m_cmp);
  endfunction

  always @(posedge clk) begin
    if (rst) begin
      m_timer = 0; m_cmp = 0; m_mode = 0; m_en = 0; m_acq = 0;
      m_state = 0; m_cnt = 0; m_flag = 0;
    end else begin
      bit t, sw, st;
      int acq_use;
      t  = m_trig();
      sw = wr_en && wr_addr == 2 && wr_data[1] && wr_data[0];
      acq_use = (wr_en && wr_addr == 2) ? int'(wr_data[4:2]) : m_acq;
      st = ((t && m_en != 0) || sw) && m_state == 0;
      m_flag = 0;
      case (m_state)
        0: if (st) begin
             m_cnt = acq_len(acq_use);
             m_state = (m_cnt == 0) ? 2 : 1;
           end
        1: begin
             if (m_cnt == 1) m_state = 2;
             m_cnt = m_cnt - 1;
           end
        2: m_state = 3;
        default: if (conv_done) begin m_state = 0; m_flag = 1; end
      endcase
      m_timer = t ? 0 : (m_timer + 1) % 65536;
      if (wr_en) begin
        if (wr_addr == 0) m_cmp = int'(wr_data);
        else if (wr_addr == 1) m_mode = int'(wr_data[3:0]);
        else if (wr_addr == 2) begin m_en = int'(wr_data[0]); m_acq = int'(wr_data[4:2]); end
      end
      cmp_on = 1;
    end
  end

  always @(negedge clk) if (cmp_on && !rst) begin
    chk(timer_q == 16'(m_timer), "R3 timer", timer_q, m_timer);
    chk(trig_evt == m_trig(), "R1 R6 trig_evt", trig_evt, m_trig());
    chk(busy == (m_state != 0), "R2 R8 busy", busy, m_state != 0);
    chk(acq_active == (m_state == 1), "R5 acq_active", acq_active, m_state == 1);
    chk(conv_start == (m_state == 2), "R5 conv_start", conv_start, m_state == 2);
    chk(done_flag == (m_flag != 0), "R7 done_flag", done_flag, m_flag);
  end

  // ---------------- converter responder ----------------
  int  lat = 3;
  int  rcnt = 0;
  logic auto_done = 1'b0;
  logic stray_done = 1'b0;
  assign conv_done = auto_done | stray_done;

  always @(negedge clk) begin
    auto_done <= 1'b0;
    if (rcnt > 0) begin
      rcnt <= rcnt - 1;
      if (rcnt == 1) auto_done <= 1'b1;
    end
    if (conv_start) rcnt <= lat + 1;
  end

  // ---------------- stimulus ----------------
  task automatic wr(input int a, input int d);
    @(negedge clk);
    wr_en = 1'b1; wr_addr = 2'(a); wr_data = 16'(d);
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic run(input int n);
    repeat (n) @(negedge clk);
  endtask

  initial begin
    int busy_cnt, trig_cnt, maxt;
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    chk(timer_q == 16'd1 && !busy && !acq_active && !conv_start && !done_flag,
        "R10 reset state", {timer_q, busy}, 32'h10000);

    // periodic triggering, no acquisition delay
    wr(0, 9); wr(2, 1); wr(1, 11);
    run(80);

    // each acquisition length
    wr(0, 45);
    for (int v = 1; v < 8; v++) begin
      wr(2, 1 | (v << 2));
      run(120);
    end

    // converter disabled: triggers keep reloading the timer only
    wr(2, 0);
    run(40);
    busy_cnt = 0; trig_cnt = 0;
    for (int i = 0; i < 100; i++) begin
      @(negedge clk);
      if (busy) busy_cnt++;
      if (trig_evt) trig_cnt++;
    end
    chk(busy_cnt == 0, "R4 busy while disabled", busy_cnt, 0);
    chk(trig_cnt >= 2, "R3 triggers while disabled", trig_cnt, 2);

    // other mode: no trigger, timer passes the compare value
    wr(1, 10); wr(2, 1);
    trig_cnt = 0; maxt = 0;
    for (int i = 0; i < 100; i++) begin
      @(negedge clk);
      if (trig_evt) trig_cnt++;
      if (int'(timer_q) > maxt) maxt = int'(timer_q);
    end
    chk(trig_cnt == 0, "R1 no trigger in other mode", trig_cnt, 0);
    chk(maxt > 45, "R1 timer passes compare", maxt, 46);

    // software start without timer reload, then a start while busy
    @(negedge clk);
    maxt = int'(timer_q);
    wr(2, 3 | (2 << 2));
    chk(busy && timer_q != 0, "R9 software start", busy, 1);
    wr(2, 3 | (7 << 2));
    run(30);
    chk(!busy, "R9 start while busy ignored", busy, 0);

    // stray done pulses when idle and during acquisition
    stray_done = 1'b1; run(2); stray_done = 1'b0;
    wr(2, 3 | (7 << 2));
    run(4);
    stray_done = 1'b1; run(1); stray_done = 1'b0;
    chk(busy && acq_active, "R7 stray done ignored", busy, 1);
    run(40);

    // collisions: trigger vs done, trigger vs software start
    wr(0, 6); wr(2, 1); wr(1, 11);
    for (int l = 0; l < 9; l++) begin
      lat = l;
      run(40);
    end
    lat = 2;
    wr(2, 0); wr(0, 12);
    for (int k = 0; k < 14; k++) begin
      run(k + 3);
      wr(2, 3);
      run(30);
      wr(2, 0);
    end
    run(20);

    // wrap check in free-running mode
    wr(1, 0);
    run(65600);

    // reset mid-sequence
    wr(1, 11); wr(0, 3); wr(2, 1 | (7 << 2));
    run(10);
    @(negedge clk) rst = 1'b1;
    @(negedge clk) rst = 1'b0;
    chk(timer_q == 16'd0 && !busy && !done_flag, "R10 reset clears", busy, 0);
    run(20);
    chk(!busy, "R10 mode and enable cleared", busy, 0);

    finished = 1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    #(190000 * 10);
    if (!finished) begin
      total++; bad++;
      $display("FAIL watchdog actual=%0d expected=%0d", 0, 1);
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

endmodule